// File: doc/BRIEF.md
# Modulo-Indexed Local Register File

This block is a small register file that sits beside one processing element of a coarse-grained reconfigurable array. One physical array holds two kinds of values. Recurring loop variables need one copy per iteration still in flight. Nonrecurring values, such as read-only inputs and constants, need only one copy. Contents never shift between iterations. Instead, an address unit turns each logical register number into a physical index. For a recurring variable the index is the variable's base plus (offset + iteration phase) mod the variable's length. The modulo step is done by one conditional subtraction, because each variable keeps its own phase counter that wraps at its length.

A programmable boundary splits the logical space in two. Logical numbers below the boundary are looked up in a small table of recurring variables, each entry giving a base and a length of 1 to 8. Numbers at or above the boundary go straight to the physical register with the same number. Three kinds of write are accepted only while the prologue input is high: table entries, the boundary, and direct preload writes. Preload writes are how constants are put in place before the loop body starts. During the body, an advance strobe moves every variable's phase forward by one and a loop-start pulse clears all phases. Any access that cannot be resolved to a legal slot raises an error flag on its port. A flagged read returns zero and a flagged write is dropped.

Top module: `mirf_top`

## Requirements
- R1: After reset every physical register holds zero, the boundary is 0 (so every logical number is direct), all table entries have length 0, all phases are 0, and no error flag is raised.
- R2: A logical number at or above the boundary reads and writes the physical register with the same number and never raises an error. A write shows up on the read ports from the next cycle on, and both read ports are combinational.
- R3: While prologue_i is low, table writes, boundary writes and preload writes have no effect.
- R4: While prologue_i is high, a preload write stores pre_data_i at physical index pre_idx_i whatever the boundary is. If a port write resolves to the same physical index in the same cycle, the preload value is kept.
- R5: A logical number L below the boundary that falls inside the region [base, base+len) of a valid table entry maps to physical base + ((L - base) + phase) mod len, where phase is that variable's phase counter.
- R6: Each variable's phase goes up by one on each cycle with adv_i high and wraps to 0 when it reaches the variable's length. A loop_start_i pulse clears every phase and takes priority over adv_i. An accepted table write clears that variable's phase.
- R7: adv_i and loop_start_i never change stored register contents; only the mapping of recurring names moves.
- R8: A logical number below the boundary that no valid table entry covers raises the port's error flag. A flagged read returns 0 and a flagged write leaves every register unchanged.
- R9: When the covering entry's region runs past the boundary (base + len > boundary), the access raises the error flag.
- R10: A table entry whose length is 0 or greater than 8 is invalid and covers nothing. A boundary write with a value above 16 is ignored.
- R11: When the regions of several valid entries contain a logical number, the entry with the lowest variable index is used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| prologue_i | input | 1 | Enables table, boundary and preload writes |
| loop_start_i | input | 1 | Clears all iteration phases |
| adv_i | input | 1 | Advances all iteration phases |
| cfg_we_i | input | 1 | Table entry write strobe |
| cfg_var_i | input | 2 | Variable index to write |
| cfg_base_i | input | 4 | Region base of the variable |
| cfg_len_i | input | 4 | Region length (valid 1..8) |
| bnd_we_i | input | 1 | Boundary write strobe |
| bnd_i | input | 5 | New boundary (0..16) |
| pre_we_i | input | 1 | Preload write strobe |
| pre_idx_i | input | 4 | Preload physical index |
| pre_data_i | input | 32 | Preload data |
| rd0_addr_i | input | 4 | Read port 0 logical number |
| rd0_data_o | output | 32 | Read port 0 data |
| rd0_err_o | output | 1 | Read port 0 mapping error |
| rd1_addr_i | input | 4 | Read port 1 logical number |
| rd1_data_o | output | 32 | Read port 1 data |
| rd1_err_o | output | 1 | Read port 1 mapping error |
| wr_en_i | input | 1 | Port write enable |
| wr_addr_i | input | 4 | Port write logical number |
| wr_data_i | input | 32 | Port write data |
| wr_err_o | output | 1 | Port write mapping error |

## Verification
A wrong phase counter shows up at once as data from the wrong slot on the very next read of a recurring name. It also compounds: after a wrap has been missed, every later iteration reads the wrong copy. A corrupted table or boundary register changes which names raise the error flag, and that is visible in the same cycle on any read port that touches the affected range. A write that is dropped or misplaced stays hidden until that physical slot is read again. For that reason the reference model is compared on both read ports in every cycle, with addresses spread over the whole array.

// File: rtl/mirf_pkg.sv
package mirf_pkg;
  localparam int NUM_REGS = 16;
  localparam int DATA_W   = 32;
  localparam int MAX_LEN  = 8;
  localparam int NUM_VARS = 4;
  localparam int IDX_W    = $clog2(NUM_REGS);
  localparam int LEN_W    = $clog2(MAX_LEN) + 1;
  localparam int BND_W    = $clog2(NUM_REGS + 1);
  localparam int VAR_W    = $clog2(NUM_VARS);
  localparam int SUM_W    = IDX_W + 2;

  typedef logic [DATA_W-1:0] word_t;
  typedef logic [IDX_W-1:0]  idx_t;
  typedef logic [LEN_W-1:0]  len_t;
endpackage

// File: rtl/mirf_phase_ctr.sv
module mirf_phase_ctr
  import mirf_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  len_t len_i,
  input  logic clr_i,
  input  logic adv_i,
  output len_t ph_o
);
  len_t ph_q;
  len_t ph_inc;
  logic len_ok;

  assign len_ok = (len_i != '0) && (len_i <= len_t'(MAX_LEN));
  assign ph_inc = ph_q + len_t'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             ph_q <= '0;
    else if (clr_i || !len_ok) ph_q <= '0;
    else if (adv_i)          ph_q <= (ph_inc >= len_i) ? '0 : ph_inc;
  end

  assign ph_o = ph_q;
endmodule

// File: rtl/mirf_index_unit.sv
module mirf_index_unit
  import mirf_pkg::*;
(
  input  idx_t                          la_i,
  input  logic [BND_W-1:0]              bnd_i,
  input  logic [NUM_VARS-1:0][IDX_W-1:0] base_i,
  input  logic [NUM_VARS-1:0][LEN_W-1:0] len_i,
  input  logic [NUM_VARS-1:0][LEN_W-1:0] ph_i,
  output idx_t                          phys_o,
  output logic                          err_o
);
  logic [SUM_W-1:0] la_x, bnd_x, base_x, len_x, end_x, off_x, sum_x, phys_x;
  logic [VAR_W-1:0] sel;
  logic             found;

  assign la_x  = SUM_W'(la_i);
  assign bnd_x = SUM_W'(bnd_i);

  // lowest-index valid entry whose region holds the logical number
  always_comb begin
    found = 1'b0;
    sel   = '0;
    for (int v = 0; v < NUM_VARS; v++) begin
      if (!found && len_i[v] != '0 && len_i[v] <= len_t'(MAX_LEN) &&
          la_x >= SUM_W'(base_i[v]) &&
          la_x < SUM_W'(base_i[v]) + SUM_W'(len_i[v])) begin
        found = 1'b1;
        sel   = VAR_W'(v);
      end
    end
  end

  always_comb begin
    base_x = SUM_W'(base_i[sel]);
    len_x  = SUM_W'(len_i[sel]);
    end_x  = base_x + len_x;
    off_x  = la_x - base_x;
    sum_x  = off_x + SUM_W'(ph_i[sel]);
    if (sum_x >= len_x) sum_x = sum_x - len_x;
    phys_x = base_x + sum_x;
  end

  always_comb begin
    if (la_x >= bnd_x) begin
      phys_o = la_i;
      err_o  = 1'b0;
    end else if (!found || end_x > bnd_x) begin
      phys_o = la_i;
      err_o  = 1'b1;
    end else begin
      phys_o = phys_x[IDX_W-1:0];
      err_o  = 1'b0;
    end
  end
endmodule

// File: rtl/mirf_array.sv
module mirf_array
  import mirf_pkg::*;
(
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            pre_we_i,
  input  idx_t                            pre_idx_i,
  input  word_t                           pre_data_i,
  input  logic                            wr_we_i,
  input  idx_t                            wr_idx_i,
  input  word_t                           wr_data_i,
  input  idx_t                            rd0_idx_i,
  input  idx_t                            rd1_idx_i,
  output word_t                           rd0_data_o,
  output word_t                           rd1_data_o,
  output logic [NUM_REGS-1:0][DATA_W-1:0] mem_o
);
  logic [NUM_REGS-1:0][DATA_W-1:0] mem_q;

  for (genvar e = 0; e < NUM_REGS; e++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                mem_q[e] <= '0;
      else if (pre_we_i && pre_idx_i == idx_t'(e)) mem_q[e] <= pre_data_i;
      else if (wr_we_i && wr_idx_i == idx_t'(e))   mem_q[e] <= wr_data_i;
    end
  end

  assign rd0_data_o = mem_q[rd0_idx_i];
  assign rd1_data_o = mem_q[rd1_idx_i];
  assign mem_o      = mem_q;
endmodule

// File: rtl/mirf_top.sv
module mirf_top
  import mirf_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              prologue_i,
  input  logic              loop_start_i,
  input  logic              adv_i,
  input  logic              cfg_we_i,
  input  logic [VAR_W-1:0]  cfg_var_i,
  input  logic [IDX_W-1:0]  cfg_base_i,
  input  logic [LEN_W-1:0]  cfg_len_i,
  input  logic              bnd_we_i,
  input  logic [BND_W-1:0]  bnd_i,
  input  logic              pre_we_i,
  input  logic [IDX_W-1:0]  pre_idx_i,
  input  logic [DATA_W-1:0] pre_data_i,
  input  logic [IDX_W-1:0]  rd0_addr_i,
  output logic [DATA_W-1:0] rd0_data_o,
  output logic              rd0_err_o,
  input  logic [IDX_W-1:0]  rd1_addr_i,
  output logic [DATA_W-1:0] rd1_data_o,
  output logic              rd1_err_o,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              wr_err_o
);
  localparam int NPORTS = 3;

  logic [NUM_VARS-1:0][IDX_W-1:0] base_q;
  logic [NUM_VARS-1:0][LEN_W-1:0] len_q;
  logic [NUM_VARS-1:0][LEN_W-1:0] ph_q;
  logic [BND_W-1:0]               bnd_q;
  logic [NUM_REGS-1:0][DATA_W-1:0] mem_q;

  logic cfg_ok, bnd_ok, pre_ok;
  assign cfg_ok = prologue_i && cfg_we_i;
  assign bnd_ok = prologue_i && bnd_we_i && (bnd_i <= BND_W'(NUM_REGS));
  assign pre_ok = prologue_i && pre_we_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     bnd_q <= '0;
    else if (bnd_ok) bnd_q <= bnd_i;
  end

  for (genvar v = 0; v < NUM_VARS; v++) begin : g_var
    logic hit;
    assign hit = cfg_ok && (cfg_var_i == VAR_W'(v));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        base_q[v] <= '0;
        len_q[v]  <= '0;
      end else if (hit) begin
        base_q[v] <= cfg_base_i;
        len_q[v]  <= cfg_len_i;
      end
    end

    mirf_phase_ctr u_ph (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .len_i  (len_q[v]),
      .clr_i  (loop_start_i || hit),
      .adv_i  (adv_i),
      .ph_o   (ph_q[v])
    );
  end

  // port 0: read 0, port 1: read 1, port 2: write
  idx_t [NPORTS-1:0] la, phys;
  logic [NPORTS-1:0] err;
  assign la[0] = rd0_addr_i;
  assign la[1] = rd1_addr_i;
  assign la[2] = wr_addr_i;

  for (genvar p = 0; p < NPORTS; p++) begin : g_idx
    mirf_index_unit u_idx (
      .la_i   (la[p]),
      .bnd_i  (bnd_q),
      .base_i (base_q),
      .len_i  (len_q),
      .ph_i   (ph_q),
      .phys_o (phys[p]),
      .err_o  (err[p])
    );
  end

  word_t rd0_raw, rd1_raw;

  mirf_array u_arr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pre_we_i   (pre_ok),
    .pre_idx_i  (pre_idx_i),
    .pre_data_i (pre_data_i),
    .wr_we_i    (wr_en_i && !err[2]),
    .wr_idx_i   (phys[2]),
    .wr_data_i  (wr_data_i),
    .rd0_idx_i  (phys[0]),
    .rd1_idx_i  (phys[1]),
    .rd0_data_o (rd0_raw),
    .rd1_data_o (rd1_raw),
    .mem_o      (mem_q)
  );

  assign rd0_err_o  = err[0];
  assign rd1_err_o  = err[1];
  assign wr_err_o   = err[2];
  assign rd0_data_o = err[0] ? '0 : rd0_raw;
  assign rd1_data_o = err[1] ? '0 : rd1_raw;
endmodule

// File: rtl/mirf_checker.sv
module mirf_checker
  import mirf_pkg::*;
(
  input logic                            clk_i,
  input logic                            rst_ni,
  input logic                            prologue_i,
  input logic                            loop_start_i,
  input logic                            pre_we_i,
  input logic                            wr_en_i,
  input logic                            wr_err_o,
  input logic [IDX_W-1:0]                rd0_addr_i,
  input logic [DATA_W-1:0]               rd0_data_o,
  input logic                            rd0_err_o,
  input logic [DATA_W-1:0]               rd1_data_o,
  input logic                            rd1_err_o,
  input logic [BND_W-1:0]                bnd_q,
  input logic [NUM_VARS-1:0][LEN_W-1:0]  len_q,
  input logic [NUM_VARS-1:0][LEN_W-1:0]  ph_q,
  input logic [NUM_REGS-1:0][DATA_W-1:0] mem_q
);
  p_err_zero0_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd0_err_o |-> rd0_data_o == '0);
  p_err_zero1_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd1_err_o |-> rd1_data_o == '0);
  p_direct_ok_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (BND_W'(rd0_addr_i) >= bnd_q) |-> !rd0_err_o);
  p_bnd_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !prologue_i |=> $stable(bnd_q));
  p_bnd_range_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bnd_q <= BND_W'(NUM_REGS));
  p_clr_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    loop_start_i |=> ph_q == '0);
  p_wr_block_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_err_o && !(prologue_i && pre_we_i)) |=> $stable(mem_q));

  for (genvar v = 0; v < NUM_VARS; v++) begin : g_ph
    p_ph_lt_len_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ph_q[v] == '0) || (ph_q[v] < len_q[v]));
  end
endmodule

bind mirf_top mirf_checker u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .prologue_i   (prologue_i),
  .loop_start_i (loop_start_i),
  .pre_we_i     (pre_we_i),
  .wr_en_i      (wr_en_i),
  .wr_err_o     (wr_err_o),
  .rd0_addr_i   (rd0_addr_i),
  .rd0_data_o   (rd0_data_o),
  .rd0_err_o    (rd0_err_o),
  .rd1_data_o   (rd1_data_o),
  .rd1_err_o    (rd1_err_o),
  .bnd_q        (bnd_q),
  .len_q        (len_q),
  .ph_q         (ph_q),
  .mem_q        (mem_q)
);

// File: tb/mirf_top_tb_top.sv
module mirf_top_tb_top;
  import mirf_pkg::*;
  localparam int CLK_NS = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic prologue, loop_start, adv, cfg_we, bnd_we, pre_we, wr_en;
  logic [VAR_W-1:0]  cfg_var;
  logic [IDX_W-1:0]  cfg_base, pre_idx, rd0_addr, rd1_addr, wr_addr;
  logic [LEN_W-1:0]  cfg_len;
  logic [BND_W-1:0]  bnd;
  logic [DATA_W-1:0] pre_data, wr_data, rd0_data, rd1_data;
  logic rd0_err, rd1_err, wr_err;

  always #(CLK_NS/2) clk = ~clk;

  mirf_top dut_i (
    .clk_i(clk), .rst_ni(rst_n), .prologue_i(prologue), .loop_start_i(loop_start),
    .adv_i(adv), .cfg_we_i(cfg_we), .cfg_var_i(cfg_var), .cfg_base_i(cfg_base),
    .cfg_len_i(cfg_len), .bnd_we_i(bnd_we), .bnd_i(bnd), .pre_we_i(pre_we),
    .pre_idx_i(pre_idx), .pre_data_i(pre_data), .rd0_addr_i(rd0_addr),
    .rd0_data_o(rd0_data), .rd0_err_o(rd0_err), .rd1_addr_i(rd1_addr),
    .rd1_data_o(rd1_data), .rd1_err_o(rd1_err), .wr_en_i(wr_en),
    .wr_addr_i(wr_addr), .wr_data_i(wr_data), .wr_err_o(wr_err)
  );

  int n_cmp = 0, n_bad = 0;
  string tag = "R1";

  logic [DATA_W-1:0] m_mem[NUM_REGS];
  int m_base[NUM_VARS], m_len[NUM_VARS], m_ph[NUM_VARS];
  int m_bnd;

  function automatic bit len_valid(int l);
    return l >= 1 && l <= MAX_LEN;
  endfunction

  // expected mapping straight from the requirements
  function automatic void map_la(input int la, output int phys, output bit err);
    int hit;
    phys = la; err = 1'b0; hit = -1;
    if (la >= m_bnd) return;
    for (int v = NUM_VARS - 1; v >= 0; v--)
      if (len_valid(m_len[v]) && la >= m_base[v] && la < m_base[v] + m_len[v]) hit = v;
    if (hit < 0 || m_base[hit] + m_len[hit] > m_bnd) begin err = 1'b1; return; end
    phys = m_base[hit] + ((la - m_base[hit] + m_ph[hit]) % m_len[hit]);
  endfunction

  task automatic chk(string what, logic [63:0] act, logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic compare();
    int p; bit e;
    map_la(int'(rd0_addr), p, e);
    chk("rd0_err", 64'(rd0_err), 64'(e));
    chk("rd0_data", 64'(rd0_data), e ? 64'd0 : 64'(m_mem[p]));
    map_la(int'(rd1_addr), p, e);
    chk("rd1_err", 64'(rd1_err), 64'(e));
    chk("rd1_data", 64'(rd1_data), e ? 64'd0 : 64'(m_mem[p]));
    map_la(int'(wr_addr), p, e);
    chk("wr_err", 64'(wr_err), 64'(e));
  endtask

  task automatic model_step();
    int p; bit e; int cv;
    map_la(int'(wr_addr), p, e);
    if (wr_en && !e) m_mem[p] = wr_data;
    if (prologue && pre_we) m_mem[int'(pre_idx)] = pre_data;
    cv = (prologue && cfg_we) ? int'(cfg_var) : -1;
    for (int v = 0; v < NUM_VARS; v++) begin
      if (v == cv || loop_start || !len_valid(m_len[v])) m_ph[v] = 0;
      else if (adv) m_ph[v] = (m_ph[v] + 1) % m_len[v];
    end
    if (cv >= 0) begin m_base[cv] = int'(cfg_base); m_len[cv] = int'(cfg_len); end
    if (prologue && bnd_we && int'(bnd) <= NUM_REGS) m_bnd = int'(bnd);
  endtask

  task automatic idle();
    prologue = 0; loop_start = 0; adv = 0; cfg_we = 0; bnd_we = 0; pre_we = 0; wr_en = 0;
    cfg_var = '0; cfg_base = '0; cfg_len = '0; bnd = '0; pre_idx = '0; pre_data = '0;
    rd0_addr = IDX_W'($urandom); rd1_addr = IDX_W'($urandom);
    wr_addr = IDX_W'($urandom); wr_data = $urandom;
  endtask

  task automatic tick();
    #1; compare(); model_step();
  endtask

  task automatic set_cfg(int v, int b, int l);
    @(negedge clk); idle();
    prologue = 1; cfg_we = 1; cfg_var = VAR_W'(v); cfg_base = IDX_W'(b); cfg_len = LEN_W'(l);
    tick();
  endtask

  task automatic set_bnd(int b);
    @(negedge clk); idle();
    prologue = 1; bnd_we = 1; bnd = BND_W'(b);
    tick();
  endtask

  function automatic bit pct(int p);
    return ($urandom % 100) < p;
  endfunction

  task automatic run(string t, int n, int pro_p, int cfg_p, int pre_p,
                     int adv_p, int ls_p, int wr_p, bit wild);
    tag = t;
    for (int i = 0; i < n; i++) begin
      @(negedge clk); idle();
      prologue   = pct(pro_p);
      cfg_we     = pct(cfg_p);
      bnd_we     = pct(cfg_p / 2);
      pre_we     = pct(pre_p);
      adv        = pct(adv_p);
      loop_start = pct(ls_p);
      wr_en      = pct(wr_p);
      cfg_var    = VAR_W'($urandom);
      cfg_base   = IDX_W'($urandom);
      cfg_len    = wild ? LEN_W'($urandom) : LEN_W'(1 + $urandom % MAX_LEN);
      bnd        = wild ? BND_W'($urandom) : BND_W'($urandom % (NUM_REGS + 1));
      pre_idx    = pct(50) ? wr_addr : IDX_W'($urandom);
      pre_data   = $urandom;
      tick();
    end
  endtask

  initial begin
    #(CLK_NS * 150000);
    n_cmp++; n_bad++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    foreach (m_mem[i]) m_mem[i] = '0;
    for (int v = 0; v < NUM_VARS; v++) begin m_base[v] = 0; m_len[v] = 0; m_ph[v] = 0; end
    m_bnd = 0;
    idle();
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: reset state, everything direct and zero
    run("R1", 8, 0, 0, 0, 0, 0, 0, 0);
    // R2: direct region writes visible next cycle
    run("R2", 40, 0, 0, 0, 0, 0, 60, 0);
    // R4: preload and conflicts with port writes
    run("R4", 40, 100, 0, 60, 0, 0, 60, 0);
    tag = "R11";
    set_bnd(12);
    set_cfg(0, 0, 3);
    set_cfg(1, 3, 4);
    set_cfg(2, 7, 5);
    set_cfg(3, 8, 2);   // overlaps entry 2, entry 2 wins
    tag = "R4";
    for (int i = 0; i < NUM_REGS; i++) begin
      @(negedge clk); idle();
      prologue = 1; pre_we = 1; pre_idx = IDX_W'(i); pre_data = 32'hA500_0000 | i;
      tick();
    end
    run("R5", 60, 0, 0, 0, 30, 5, 50, 0);
    run("R7", 30, 0, 0, 0, 100, 0, 0, 0);
    run("R6", 60, 0, 0, 0, 60, 15, 40, 0);
    run("R11", 30, 0, 0, 0, 50, 0, 30, 0);
    run("R3", 40, 0, 60, 50, 30, 0, 30, 1);
    tag = "R9";
    set_bnd(10);        // entry 2 now runs past the boundary
    run("R9", 40, 0, 0, 0, 50, 0, 40, 0);
    tag = "R8";
    set_cfg(1, 3, 0);   // length 0: logical 3..6 uncovered
    run("R8", 40, 0, 0, 0, 50, 0, 60, 0);
    run("R10", 60, 100, 40, 20, 40, 10, 40, 1);
    run("R6", 400, 50, 20, 20, 50, 10, 50, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule